// File: doc/BRIEF.md
# Inbound Request Abort Filter

This block sits on the inbound side of a downstream I/O port, between the link receive logic and the core fabric. Traffic from the attached south-side hub arrives one beat at a time as posted requests, non-posted requests or completions. A software-controlled abort bit selects whether inbound requests reach the fabric. While the abort is in force, posted requests are absorbed and lost. Each non-posted request is instead answered locally with a data-less Unsupported Request completion that returns the request's requester ID and tag. Completions that answer earlier outbound requests always pass. When the port is strapped for native PCI Express operation, the abort bit has no effect.

The abort bit comes out of reset set, so the port starts out blocking until software clears it. The pass, drop or answer decision is made on the first beat of a transaction and held until its last beat, so a change to the bit never splits a transaction. A second configuration word holds a reset-done acknowledge flag. Hardware sets it and software clears it by writing 1. Two counters report how many posted requests were dropped and how many non-posted requests were answered with a completion.

Top module: `inbound_abort_filter`

## Requirements
- R1: Configuration word at cfgAddr 0 holds the abort bit in bit 0. It reads 1 after reset, takes bit 0 of the written value, and its bits 31:1 always read 0.
- R2: Configuration word at cfgAddr 1 holds the acknowledge flag in bit 0. It reads 0 after reset and is set by a resetDoneEvent pulse. Writing it with bit 0 = 1 clears it, and writing bit 0 = 0 leaves it unchanged. A set and a clear in the same cycle leave it set. Bits 31:1 read 0.
- R3: With abort = 1 and nativeMode = 0, every beat of a posted request (inKind 0, and also the unused code 3) is accepted and none is forwarded. dropCount increments once per transaction.
- R4: With abort = 1 and nativeMode = 0, no beat of a non-posted request (inKind 1) is forwarded. Exactly one completion is issued, with cplStatus = 3'b001 (Unsupported Request) and the requester ID and tag of the request's first beat. urCount increments once per transaction.
- R5: Completions (inKind 2) are forwarded beat for beat whatever the abort bit holds.
- R6: With abort = 0, every beat of every transaction class is forwarded, and no completion is generated.
- R7: With nativeMode = 1, every class is forwarded whatever the abort bit holds.
- R8: A generated completion holds its valid and fields stable until cplReady. While it waits, the last beat of the next blocked non-posted request is stalled (inReady = 0), so that no request goes unanswered.
- R9: The abort decision is taken on the first beat (the beat after an inLast beat, or the first after reset). A change of the bit during a multi-beat transaction does not affect that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nativeMode | input | 1 | 1 = native PCI Express mode, abort ignored |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgAddr | input | 1 | 0 = abort control word, 1 = acknowledge status word |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read data for cfgAddr |
| resetDoneEvent | input | 1 | Pulse that sets the acknowledge flag |
| inValid | input | 1 | Inbound beat valid |
| inReady | output | 1 | Inbound beat accepted when high with inValid |
| inKind | input | 2 | 0 posted, 1 non-posted, 2 completion, 3 unused (treated as posted) |
| inReqId | input | 16 | Requester ID |
| inTag | input | 8 | Transaction tag |
| inData | input | 32 | Beat payload |
| inLast | input | 1 | Last beat of transaction |
| fwdValid | output | 1 | Forwarded beat valid |
| fwdReady | input | 1 | Fabric accepts forwarded beat |
| fwdKind | output | 2 | Forwarded transaction class |
| fwdReqId | output | 16 | Forwarded requester ID |
| fwdTag | output | 8 | Forwarded tag |
| fwdData | output | 32 | Forwarded payload |
| fwdLast | output | 1 | Forwarded last beat |
| cplValid | output | 1 | Generated completion valid |
| cplReady | input | 1 | Completion sink ready |
| cplReqId | output | 16 | Requester ID of aborted request |
| cplTag | output | 8 | Tag of aborted request |
| cplStatus | output | 3 | Completion status, 3'b001 = Unsupported Request |
| dropCount | output | 16 | Posted requests dropped |
| urCount | output | 16 | Non-posted requests answered with UR |

## Verification
The bench sweeps every combination of mode, abort setting, transaction class and length from one to three beats. A filter that keyed on the wrong class would forward requests it should block, or would answer posted writes. Multi-beat non-posted requests carry a different ID and tag on their later beats, so a completion built from the last beat instead of the first shows up as a wrong tag. Holding back cplReady while a second blocked non-posted request arrives shows whether a design overwrites a pending completion or lets the request through unanswered. Flipping the abort bit mid-transaction shows whether a design splits a transaction between passing and blocking. The write-1-to-clear flag is checked against writes of 0, writes of 1 and a set and a clear in the same cycle.

// File: rtl/abort_filter_pkg.sv
`timescale 1ns/1ps
package abort_filter_pkg;

  typedef enum logic [1:0] {
    KIND_POSTED    = 2'd0,
    KIND_NONPOSTED = 2'd1,
    KIND_CPL       = 2'd2,
    KIND_UNUSED    = 2'd3
  } txnKind_e;

  localparam logic [2:0] CPL_STATUS_UR = 3'b001;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic captureHdr;   // first beat accepted: latch header
    logic issueCpl;     // last beat of blocked non-posted accepted
    logic dropDone;     // last beat of blocked posted accepted
    logic useCaptured;  // current beat is not the first one
  } filterStrobe_t;

endpackage

// File: rtl/abort_filter_ctrl.sv
`timescale 1ns/1ps
module abort_filter_ctrl
  import abort_filter_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nativeMode,
  input  logic             cfgWrite,
  input  logic             cfgAddr,
  input  logic [REG_W-1:0] cfgWdata,
  output logic [REG_W-1:0] cfgRdata,
  input  logic             resetDoneEvent,
  input  logic             inValid,
  input  logic [1:0]       inKind,
  input  logic             inLast,
  output logic             inReady,
  output logic             fwdValid,
  input  logic             fwdReady,
  input  logic             cplBusy,
  output filterStrobe_t    strobe,
  output logic             pktActive
);

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_ACK  = 1'b1;

  logic       abortQ;
  logic       ackQ;
  logic       pktActiveQ;
  logic       pktBlockQ;
  logic [1:0] pktKindQ;

  logic       firstBeat;
  logic       blockFresh;
  logic       blockNow;
  logic [1:0] kindNow;
  logic       isNonPosted;
  logic       accept;

  // Configuration words
  always_ff @(posedge clk) begin
    if (rst) begin
      abortQ <= 1'b1;
      ackQ   <= 1'b0;
    end else begin
      if (cfgWrite && cfgAddr == ADDR_CTRL) abortQ <= cfgWdata[0];
      if (resetDoneEvent) ackQ <= 1'b1;
      else if (cfgWrite && cfgAddr == ADDR_ACK && cfgWdata[0]) ackQ <= 1'b0;
    end
  end

  always_comb begin
    cfgRdata    = '0;
    cfgRdata[0] = (cfgAddr == ADDR_ACK) ? ackQ : abortQ;
  end

  // Per-transaction decision
  always_comb begin
    firstBeat   = !pktActiveQ;
    blockFresh  = abortQ && !nativeMode && (inKind != KIND_CPL);
    blockNow    = firstBeat ? blockFresh : pktBlockQ;
    kindNow     = firstBeat ? inKind : pktKindQ;
    isNonPosted = (kindNow == KIND_NONPOSTED);
    if (!blockNow)                inReady = fwdReady;
    else if (isNonPosted && inLast) inReady = !cplBusy;
    else                          inReady = 1'b1;
    fwdValid = inValid && !blockNow;
    accept   = inValid && inReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pktActiveQ <= 1'b0;
      pktBlockQ  <= 1'b0;
      pktKindQ   <= 2'd0;
    end else if (accept) begin
      pktActiveQ <= !inLast;
      if (firstBeat) begin
        pktBlockQ <= blockFresh;
        pktKindQ  <= inKind;
      end
    end
  end

  always_comb begin
    strobe.captureHdr  = accept && firstBeat;
    strobe.issueCpl    = accept && inLast && blockNow && isNonPosted;
    strobe.dropDone    = accept && inLast && blockNow && !isNonPosted;
    strobe.useCaptured = !firstBeat;
  end

  assign pktActive = pktActiveQ;

endmodule

// File: rtl/abort_filter_dpath.sv
`timescale 1ns/1ps
module abort_filter_dpath
  import abort_filter_pkg::*;
#(
  parameter int REQ_ID_W = 16,
  parameter int TAG_W    = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  filterStrobe_t       strobe,
  input  logic [1:0]          inKind,
  input  logic [REQ_ID_W-1:0] inReqId,
  input  logic [TAG_W-1:0]    inTag,
  input  logic [DATA_W-1:0]   inData,
  input  logic                inLast,
  output logic [1:0]          fwdKind,
  output logic [REQ_ID_W-1:0] fwdReqId,
  output logic [TAG_W-1:0]    fwdTag,
  output logic [DATA_W-1:0]   fwdData,
  output logic                fwdLast,
  output logic                cplValid,
  input  logic                cplReady,
  output logic [REQ_ID_W-1:0] cplReqId,
  output logic [TAG_W-1:0]    cplTag,
  output logic [2:0]          cplStatus,
  output logic                cplBusy,
  output logic [CNT_W-1:0]    dropCount,
  output logic [CNT_W-1:0]    urCount
);

  logic [REQ_ID_W-1:0] hdrReqIdQ;
  logic [TAG_W-1:0]    hdrTagQ;
  logic [REQ_ID_W-1:0] hdrReqIdSel;
  logic [TAG_W-1:0]    hdrTagSel;
  logic                cplValidQ;
  logic [REQ_ID_W-1:0] cplReqIdQ;
  logic [TAG_W-1:0]    cplTagQ;
  logic [2:0]          cplStatusQ;
  logic [CNT_W-1:0]    dropCntQ;
  logic [CNT_W-1:0]    urCntQ;

  // Forwarding is a straight pass of the beat fields.
  assign fwdKind  = inKind;
  assign fwdReqId = inReqId;
  assign fwdTag   = inTag;
  assign fwdData  = inData;
  assign fwdLast  = inLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdrReqIdQ <= '0;
      hdrTagQ   <= '0;
    end else if (strobe.captureHdr) begin
      hdrReqIdQ <= inReqId;
      hdrTagQ   <= inTag;
    end
  end

  assign hdrReqIdSel = strobe.useCaptured ? hdrReqIdQ : inReqId;
  assign hdrTagSel   = strobe.useCaptured ? hdrTagQ   : inTag;

  // One-entry completion slot
  always_ff @(posedge clk) begin
    if (rst) begin
      cplValidQ  <= 1'b0;
      cplReqIdQ  <= '0;
      cplTagQ    <= '0;
      cplStatusQ <= '0;
    end else if (strobe.issueCpl) begin
      cplValidQ  <= 1'b1;
      cplReqIdQ  <= hdrReqIdSel;
      cplTagQ    <= hdrTagSel;
      cplStatusQ <= CPL_STATUS_UR;
    end else if (cplValidQ && cplReady) begin
      cplValidQ  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dropCntQ <= '0;
      urCntQ   <= '0;
    end else begin
      if (strobe.dropDone) dropCntQ <= dropCntQ + 1'b1;
      if (strobe.issueCpl) urCntQ   <= urCntQ + 1'b1;
    end
  end

  assign cplValid  = cplValidQ;
  assign cplReqId  = cplReqIdQ;
  assign cplTag    = cplTagQ;
  assign cplStatus = cplStatusQ;
  assign cplBusy   = cplValidQ;
  assign dropCount = dropCntQ;
  assign urCount   = urCntQ;

endmodule

// File: rtl/inbound_abort_filter.sv
`timescale 1ns/1ps
module inbound_abort_filter
  import abort_filter_pkg::*;
#(
  parameter int REQ_ID_W = 16,
  parameter int TAG_W    = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int REG_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                nativeMode,
  input  logic                cfgWrite,
  input  logic                cfgAddr,
  input  logic [REG_W-1:0]    cfgWdata,
  output logic [REG_W-1:0]    cfgRdata,
  input  logic                resetDoneEvent,
  input  logic                inValid,
  output logic                inReady,
  input  logic [1:0]          inKind,
  input  logic [REQ_ID_W-1:0] inReqId,
  input  logic [TAG_W-1:0]    inTag,
  input  logic [DATA_W-1:0]   inData,
  input  logic                inLast,
  output logic                fwdValid,
  input  logic                fwdReady,
  output logic [1:0]          fwdKind,
  output logic [REQ_ID_W-1:0] fwdReqId,
  output logic [TAG_W-1:0]    fwdTag,
  output logic [DATA_W-1:0]   fwdData,
  output logic                fwdLast,
  output logic                cplValid,
  input  logic                cplReady,
  output logic [REQ_ID_W-1:0] cplReqId,
  output logic [TAG_W-1:0]    cplTag,
  output logic [2:0]          cplStatus,
  output logic [CNT_W-1:0]    dropCount,
  output logic [CNT_W-1:0]    urCount
);

  filterStrobe_t strobe;
  logic          cplBusy;
  logic          pktActive;

  abort_filter_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst(rst), .nativeMode(nativeMode),
    .cfgWrite(cfgWrite), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .resetDoneEvent(resetDoneEvent),
    .inValid(inValid), .inKind(inKind), .inLast(inLast), .inReady(inReady),
    .fwdValid(fwdValid), .fwdReady(fwdReady), .cplBusy(cplBusy),
    .strobe(strobe), .pktActive(pktActive)
  );

  abort_filter_dpath #(
    .REQ_ID_W(REQ_ID_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .inKind(inKind), .inReqId(inReqId), .inTag(inTag), .inData(inData),
    .inLast(inLast),
    .fwdKind(fwdKind), .fwdReqId(fwdReqId), .fwdTag(fwdTag),
    .fwdData(fwdData), .fwdLast(fwdLast),
    .cplValid(cplValid), .cplReady(cplReady), .cplReqId(cplReqId),
    .cplTag(cplTag), .cplStatus(cplStatus), .cplBusy(cplBusy),
    .dropCount(dropCount), .urCount(urCount)
  );

endmodule

// File: rtl/abort_filter_checker.sv
`timescale 1ns/1ps
module abort_filter_checker #(
  parameter int REQ_ID_W = 16,
  parameter int TAG_W    = 8,
  parameter int CNT_W    = 16,
  parameter int REG_W    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                nativeMode,
  input logic                cfgWrite,
  input logic                cfgAddr,
  input logic [REG_W-1:0]    cfgWdata,
  input logic [REG_W-1:0]    cfgRdata,
  input logic                resetDoneEvent,
  input logic                inValid,
  input logic                inReady,
  input logic [1:0]          inKind,
  input logic                inLast,
  input logic                fwdValid,
  input logic                cplValid,
  input logic                cplReady,
  input logic [REQ_ID_W-1:0] cplReqId,
  input logic [TAG_W-1:0]    cplTag,
  input logic [2:0]          cplStatus,
  input logic [CNT_W-1:0]    dropCount,
  input logic [CNT_W-1:0]    urCount,
  input logic                pktActive
);

  assert_cpl_hold_R8: assert property (@(posedge clk) disable iff (rst)
    cplValid && !cplReady |=> cplValid && $stable(cplTag) && $stable(cplReqId));

  assert_cpl_status_R4: assert property (@(posedge clk) disable iff (rst)
    cplValid |-> cplStatus == 3'b001);

  assert_ur_count_R4: assert property (@(posedge clk) disable iff (rst)
    urCount != $past(urCount) |-> cplValid);

  assert_drop_count_R3: assert property (@(posedge clk) disable iff (rst)
    dropCount != $past(dropCount) |-> $past(inValid && inReady && inLast && !fwdValid));

  assert_cpl_passes_R5: assert property (@(posedge clk) disable iff (rst)
    inValid && !pktActive && inKind == 2'd2 |-> fwdValid);

  assert_native_pass_R7: assert property (@(posedge clk) disable iff (rst)
    nativeMode && inValid && !pktActive |-> fwdValid);

  assert_ack_clear_R2: assert property (@(posedge clk) disable iff (rst)
    cfgWrite && cfgAddr && cfgWdata[0] && !resetDoneEvent |=> !(cfgAddr && cfgRdata[0]));

endmodule

bind inbound_abort_filter abort_filter_checker #(
  .REQ_ID_W(REQ_ID_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst(rst), .nativeMode(nativeMode), .cfgWrite(cfgWrite),
  .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
  .resetDoneEvent(resetDoneEvent), .inValid(inValid), .inReady(inReady),
  .inKind(inKind), .inLast(inLast), .fwdValid(fwdValid),
  .cplValid(cplValid), .cplReady(cplReady), .cplReqId(cplReqId),
  .cplTag(cplTag), .cplStatus(cplStatus), .dropCount(dropCount),
  .urCount(urCount), .pktActive(pktActive)
);

// File: tb/sim_inbound_abort_filter.sv
`timescale 1ns/1ps
module sim_inbound_abort_filter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nativeMode = 1'b0;
  logic        cfgWrite = 1'b0;
  logic        cfgAddr = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        resetDoneEvent = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  inKind = '0;
  logic [15:0] inReqId = '0;
  logic [7:0]  inTag = '0;
  logic [31:0] inData = '0;
  logic        inLast = 1'b0;
  logic        fwdValid;
  logic        fwdReady = 1'b1;
  logic [1:0]  fwdKind;
  logic [15:0] fwdReqId;
  logic [7:0]  fwdTag;
  logic [31:0] fwdData;
  logic        fwdLast;
  logic        cplValid;
  logic        cplReady = 1'b1;
  logic [15:0] cplReqId;
  logic [7:0]  cplTag;
  logic [2:0]  cplStatus;
  logic [15:0] dropCount;
  logic [15:0] urCount;

  int checks = 0;
  int failures = 0;
  int fwdBeats = 0;
  int cplSeen = 0;
  int tagLog[64];
  int ridLog[64];
  int statLog[64];

  always #2 clk = ~clk;

  inbound_abort_filter u0 (.*);

  // Monitor: handshake seen between edges happens at the next rising edge.
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (fwdValid && fwdReady) fwdBeats++;
      if (cplValid && cplReady) begin
        tagLog[cplSeen % 64]  = int'(cplTag);
        ridLog[cplSeen % 64]  = int'(cplReqId);
        statLog[cplSeen % 64] = int'(cplStatus);
        cplSeen++;
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWr(input logic a, input logic [31:0] d);
    @(negedge clk);
    cfgWrite = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic cfgRd(input logic a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdata;
  endtask

  // flipBeat >= 0: write abort=flipVal on that beat's drive cycle.
  task automatic sendTxn(input int kind, input int beats, input int rid,
                         input int tag, input int flipBeat, input logic flipVal);
    for (int b = 0; b < beats; b++) begin
      forever begin
        @(negedge clk);
        cfgWrite = (b == flipBeat);
        cfgAddr  = 1'b0;
        cfgWdata = {31'd0, flipVal};
        inValid  = 1'b1;
        inKind   = 2'(kind);
        inReqId  = (b == 0) ? 16'(rid) : ~16'(rid);
        inTag    = (b == 0) ? 8'(tag) : ~8'(tag);
        inData   = 32'(b * 7 + tag);
        inLast   = (b == beats - 1);
        #1;
        if (inReady) begin
          @(posedge clk);
          break;
        end
      end
    end
    @(negedge clk);
    inValid = 1'b0; cfgWrite = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int fb0, cs0, dc0, uc0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1/R2 reset state
    cfgRd(1'b0, rd); chk("R1 abort reset", rd, 1);
    cfgRd(1'b1, rd); chk("R2 ack reset", rd, 0);
    chk("R4 cplValid reset", cplValid, 0);
    chk("R3 dropCount reset", dropCount, 0);
    chk("R4 urCount reset", urCount, 0);

    // R2 write-1-to-clear flag
    @(negedge clk); resetDoneEvent = 1'b1; @(negedge clk); resetDoneEvent = 1'b0;
    cfgRd(1'b1, rd); chk("R2 ack set", rd, 1);
    cfgWr(1'b1, 32'hFFFF_FFFE);
    cfgRd(1'b1, rd); chk("R2 write 0 keeps", rd, 1);
    @(negedge clk); cfgWrite = 1'b1; cfgAddr = 1'b1; cfgWdata = 32'h1; resetDoneEvent = 1'b1;
    @(negedge clk); cfgWrite = 1'b0; resetDoneEvent = 1'b0;
    cfgRd(1'b1, rd); chk("R2 set beats clear", rd, 1);
    cfgWr(1'b1, 32'hFFFF_FFFF);
    cfgRd(1'b1, rd); chk("R2 w1c clears, upper zero", rd, 0);

    // R1 control word
    cfgWr(1'b0, 32'hFFFF_FFFE);
    cfgRd(1'b0, rd); chk("R1 abort written 0", rd, 0);
    cfgWr(1'b0, 32'hFFFF_FFFF);
    cfgRd(1'b0, rd); chk("R1 abort 1 upper zero", rd, 1);

    // Sweep: mode x abort x kind x length (R3 R4 R5 R6 R7)
    for (int nm = 0; nm < 2; nm++) begin
      for (int ab = 0; ab < 2; ab++) begin
        @(negedge clk); nativeMode = nm[0];
        cfgWr(1'b0, 32'(ab));
        for (int k = 0; k < 4; k++) begin
          for (int bl = 1; bl <= 3; bl++) begin
            automatic bit blocked = (ab == 1) && (nm == 0) && (k != 2);
            automatic int tg = (nm * 97 + ab * 41 + k * 13 + bl * 5) & 255;
            automatic int rid = 16'h1000 + tg * 3;
            fb0 = fwdBeats; cs0 = cplSeen; dc0 = dropCount; uc0 = urCount;
            sendTxn(k, bl, rid, tg, -1, 1'b0);
            settle();
            chk(blocked ? "R3/R4 fwd beats blocked" :
                (nm == 1 ? "R7 fwd beats native" : (k == 2 ? "R5 cpl fwd" : "R6 fwd beats")),
                fwdBeats - fb0, blocked ? 0 : bl);
            chk("R4 cpl issued", cplSeen - cs0, (blocked && k == 1) ? 1 : 0);
            chk("R3 dropCount", dropCount - dc0, (blocked && k != 1) ? 1 : 0);
            chk("R4 urCount", urCount - uc0, (blocked && k == 1) ? 1 : 0);
            if (blocked && k == 1) begin
              chk("R4 cpl tag first beat", tagLog[(cplSeen - 1) % 64], tg);
              chk("R4 cpl reqId first beat", ridLog[(cplSeen - 1) % 64], rid);
              chk("R4 cpl status UR", statLog[(cplSeen - 1) % 64], 1);
            end
          end
        end
      end
    end

    // R8 back-pressure on completion slot
    @(negedge clk); nativeMode = 1'b0; cplReady = 1'b0;
    cfgWr(1'b0, 32'h1);
    cs0 = cplSeen;
    sendTxn(1, 1, 16'h0A0A, 8'h11, -1, 1'b0);
    fork
      sendTxn(1, 2, 16'h0B0B, 8'h22, -1, 1'b0);
      begin
        repeat (6) @(negedge clk);
        #1;
        chk("R8 input stalled", inReady, 0);
        chk("R8 cpl held tag", cplTag, 8'h11);
        chk("R8 cpl held valid", cplValid, 1);
        cplReady = 1'b1;
      end
    join
    settle();
    chk("R8 both cpls", cplSeen - cs0, 2);
    chk("R8 order first", tagLog[cs0 % 64], 8'h11);
    chk("R8 order second", tagLog[(cs0 + 1) % 64], 8'h22);

    // R9 abort change mid-transaction
    cfgWr(1'b0, 32'h0);
    fb0 = fwdBeats; dc0 = dropCount;
    sendTxn(0, 3, 16'h0C0C, 8'h33, 1, 1'b1);
    settle();
    chk("R9 passing txn kept whole", fwdBeats - fb0, 3);
    chk("R9 no drop mid-txn", dropCount - dc0, 0);
    cfgRd(1'b0, rd); chk("R9 abort now set", rd, 1);
    fb0 = fwdBeats;
    sendTxn(0, 3, 16'h0D0D, 8'h44, 1, 1'b0);
    settle();
    chk("R9 blocked txn kept whole", fwdBeats - fb0, 0);
    chk("R9 drop counted once", dropCount - dc0, 1);
    fb0 = fwdBeats;
    sendTxn(0, 1, 16'h0E0E, 8'h55, -1, 1'b0);
    settle();
    chk("R9 next txn uses new bit", fwdBeats - fb0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule